// File: doc/BRIEF.md
# Field-Difference Laser Peak Locator

This block finds a projected laser stripe in interlaced video. The camera sees the scene with the laser off during the even field and with the laser on during the odd field. The block stores the even field as a reduced image in an internal buffer. When the odd field arrives, it subtracts the stored sample from each live sample at the same line and pixel position. Ambient light appears in both fields and therefore cancels, so only the stripe is left.

For every line of the live field, the block tracks the largest difference and where it occurs. At the end of the line it emits that position as a one-cycle result. The position stands for one range bin, and a full live field gives one result per buffered line. A result value of all ones means that no beam was found on that line. Sync separation, digitizer control and transfer to a host are handled elsewhere.

Top module: `peak_locator`

## Requirements
- R1: A field-start with fieldOdd=0 starts a reference capture. The first PIXELS accepted pixels of each of the first LINES lines are stored, addressed by line and pixel index.
- R2: On a live line, each pixel's difference is the live sample minus the stored sample at the same line and pixel. A negative difference is clamped to zero.
- R3: The reported position is the pixel index (0 to PIXELS-1) of the largest difference on the line. On a tie, the lowest index is reported.
- R4: If the line's largest difference is strictly below `threshold`, resPos is 0xFF (all ones). A maximum equal to the threshold reports its position.
- R5: resValid pulses for one cycle, one clock after the PIXELS-th accepted pixel of a live line. A complete live field yields exactly LINES results.
- R6: acqDone pulses in the same cycle as the result of live line LINES-1, and at no other time.
- R7: A field-start that arrives before the reference is complete abandons the capture. An even field-start restarts the capture. An odd field-start that arrives before a complete reference produces no results.
- R8: The following are ignored: pixels beyond PIXELS on a line, lines beyond LINES in a field, pixels outside a line, and a pixel in the same cycle as lineStart or fieldStart. A line is numbered by the count of lineStart pulses since fieldStart, starting at 0.
- R9: After acqDone, a new reference field is required. A following odd field yields no results.
- R10: During and right after reset, resValid and acqDone are low and resPos is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel sample valid |
| pixData | input | DW | Pixel intensity |
| lineStart | input | 1 | Pulse before the first pixel of a line |
| fieldStart | input | 1 | Pulse at the start of a field |
| fieldOdd | input | 1 | Field parity, sampled with fieldStart (1 = odd, laser on) |
| threshold | input | DW | Minimum difference counted as a beam |
| resValid | output | 1 | One result is present |
| resPos | output | RW | Peak pixel index, or all ones for no beam |
| acqDone | output | 1 | Last result of the acquisition |

## Verification
The hardest situations to reach from the ports are sequencing corners. One is a field-start that cuts off a reference capture partway through. Another is an odd field that arrives with no valid reference, either before any capture or after a finished acquisition. The stimulus sends truncated even fields of different lengths, then odd fields, and then repeats an odd field after completion. Overlong fields are also sent, with extra lines, extra pixels and pixels in the same cycle as lineStart, all set to full scale so that any one of them would win the maximum if it were taken. The live image is built so that particular lines show a tie, a clamped negative difference, a maximum exactly at the threshold and a maximum just below it.

// File: rtl/peak_locator_pkg.sv
package peak_locator_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_READY = 2'd2,
    ST_LIVE  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic wrRef;     // store sample into reference buffer
    logic accum;     // fold difference into running maximum
    logic first;     // pixel index 0 of a line
    logic last;      // final buffered pixel of a line
    logic lastLine;  // final buffered line of a field
  } ctl_stb_t;
endpackage

// File: rtl/peak_locator_ctrl.sv
module peak_locator_ctrl
  import peak_locator_pkg::*;
#(
  parameter int LINES  = 128,
  parameter int PIXELS = 16,
  localparam int LW = $clog2(LINES),
  localparam int PW = $clog2(PIXELS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic          lineStart,
  input  logic          fieldStart,
  input  logic          fieldOdd,
  output ctl_stb_t      stb,
  output logic [LW-1:0] lineAddr,
  output logic [PW-1:0] pixAddr
);
  seq_state_t    state;
  logic [LW:0]   lineNum;
  logic [LW-1:0] curLine;
  logic [PW-1:0] pixIdx;
  logic          inLine;
  logic          take;

  always_comb begin
    take         = pixValid && inLine && !fieldStart && !lineStart;
    stb.wrRef    = take && (state == ST_CAPT);
    stb.accum    = take && (state == ST_LIVE);
    stb.first    = (pixIdx == '0);
    stb.last     = (pixIdx == PW'(PIXELS - 1));
    stb.lastLine = (curLine == LW'(LINES - 1));
    lineAddr     = curLine;
    pixAddr      = pixIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lineNum <= '0;
      curLine <= '0;
      pixIdx  <= '0;
      inLine  <= 1'b0;
    end else if (fieldStart) begin
      if (!fieldOdd)               state <= ST_CAPT;
      else if (state == ST_READY)  state <= ST_LIVE;
      else                         state <= ST_IDLE;
      lineNum <= '0;
      inLine  <= 1'b0;
    end else if (lineStart) begin
      if (lineNum < (LW+1)'(LINES)) begin
        curLine <= lineNum[LW-1:0];
        lineNum <= lineNum + 1'b1;
        pixIdx  <= '0;
        inLine  <= 1'b1;
      end else begin
        inLine  <= 1'b0;
      end
    end else if (take) begin
      pixIdx <= pixIdx + 1'b1;
      if (stb.last) begin
        inLine <= 1'b0;
        if (stb.lastLine && state == ST_CAPT) state <= ST_READY;
        if (stb.lastLine && state == ST_LIVE) state <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/peak_locator_dpath.sv
module peak_locator_dpath
  import peak_locator_pkg::*;
#(
  parameter int LINES  = 128,
  parameter int PIXELS = 16,
  parameter int DW     = 8,
  parameter int RW     = 8,
  localparam int LW = $clog2(LINES),
  localparam int PW = $clog2(PIXELS),
  localparam int AW = $clog2(LINES * PIXELS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_stb_t      stb,
  input  logic [LW-1:0] lineAddr,
  input  logic [PW-1:0] pixAddr,
  input  logic [DW-1:0] pixData,
  input  logic [DW-1:0] threshold,
  output logic          resValid,
  output logic [RW-1:0] resPos,
  output logic          acqDone
);
  logic [DW-1:0] refMem [LINES*PIXELS];
  logic [AW-1:0] addr;
  logic [DW-1:0] refPix;
  logic [DW:0]   rawDiff;
  logic [DW-1:0] clampDiff;
  logic [DW-1:0] maxVal, curVal;
  logic [PW-1:0] maxPos, curPos;
  logic          better;

  always_comb begin
    addr      = AW'(lineAddr) * AW'(PIXELS) + AW'(pixAddr);
    refPix    = refMem[addr];
    rawDiff   = {1'b0, pixData} - {1'b0, refPix};
    clampDiff = rawDiff[DW] ? '0 : rawDiff[DW-1:0];
    better    = stb.first || (clampDiff > maxVal);
    curVal    = better ? clampDiff : maxVal;
    curPos    = better ? pixAddr : maxPos;
  end

  always_ff @(posedge clk) begin
    if (stb.wrRef) refMem[addr] <= pixData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxVal   <= '0;
      maxPos   <= '0;
      resValid <= 1'b0;
      resPos   <= '0;
      acqDone  <= 1'b0;
    end else begin
      resValid <= stb.accum && stb.last;
      acqDone  <= stb.accum && stb.last && stb.lastLine;
      if (stb.accum) begin
        maxVal <= curVal;
        maxPos <= curPos;
        if (stb.last) resPos <= (curVal < threshold) ? '1 : RW'(curPos);
      end
    end
  end
endmodule

// File: rtl/peak_locator.sv
module peak_locator
  import peak_locator_pkg::*;
#(
  parameter int LINES  = 128,
  parameter int PIXELS = 16,
  parameter int DW     = 8,
  parameter int RW     = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic [DW-1:0] pixData,
  input  logic          lineStart,
  input  logic          fieldStart,
  input  logic          fieldOdd,
  input  logic [DW-1:0] threshold,
  output logic          resValid,
  output logic [RW-1:0] resPos,
  output logic          acqDone
);
  localparam int LW = $clog2(LINES);
  localparam int PW = $clog2(PIXELS);

  ctl_stb_t      ctlStb;
  logic [LW-1:0] lineAddr;
  logic [PW-1:0] pixAddr;

  peak_locator_ctrl #(.LINES(LINES), .PIXELS(PIXELS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .fieldStart(fieldStart), .fieldOdd(fieldOdd), .stb(ctlStb),
    .lineAddr(lineAddr), .pixAddr(pixAddr)
  );

  peak_locator_dpath #(.LINES(LINES), .PIXELS(PIXELS), .DW(DW), .RW(RW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .lineAddr(lineAddr), .pixAddr(pixAddr),
    .pixData(pixData), .threshold(threshold), .resValid(resValid),
    .resPos(resPos), .acqDone(acqDone)
  );
endmodule

// File: rtl/peak_locator_chk.sv
module peak_locator_chk
  import peak_locator_pkg::*;
#(
  parameter int PIXELS = 16,
  parameter int RW     = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          fieldStart,
  input logic          resValid,
  input logic [RW-1:0] resPos,
  input logic          acqDone,
  input ctl_stb_t      stb
);
  // R6: completion coincides with a result
  a_r6_done_with_result: assert property (@(posedge clk) disable iff (!rstN)
    acqDone |-> resValid);

  // R3 / R4: a result is either a legal index or the no-beam code
  a_r4_pos_legal: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resPos == '1 || resPos < RW'(PIXELS)));

  // R5: results are single-cycle pulses following a line's final live pixel
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  a_r5_after_last_pixel: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(stb.accum && stb.last));

  // R8: a field-start cycle never yields a result on the next clock
  a_r8_fieldstart_blocks: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> !resValid);

  // R1: capture and differencing never run together
  a_r1_exclusive_modes: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrRef && stb.accum));
endmodule

bind peak_locator peak_locator_chk #(.PIXELS(PIXELS), .RW(RW)) u_chk (
  .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .resValid(resValid),
  .resPos(resPos), .acqDone(acqDone), .stb(ctlStb)
);

// File: tb/sim_peak_locator.sv
`timescale 1ns/1ps
module sim_peak_locator;
  localparam int L = 128;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixValid = 1'b0;
  logic [7:0] pixData = '0;
  logic       lineStart = 1'b0;
  logic       fieldStart = 1'b0;
  logic       fieldOdd = 1'b0;
  logic [7:0] threshold = 8'd20;
  logic       resValid;
  logic [7:0] resPos;
  logic       acqDone;

  int tests = 0;
  int fails = 0;
  bit started = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  peak_locator u0 (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .lineStart(lineStart), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
    .threshold(threshold), .resValid(resValid), .resPos(resPos), .acqDone(acqDone)
  );

  // ---------------- behavioural reference model ----------------
  int  refM [L][P];
  int  mState = 0;  // 0 none, 1 capturing, 2 reference ready, 3 live
  int  mLines = 0, mCur = 0, mPix = 0, mMaxV = 0, mMaxP = 0;
  bit  mIn = 0;
  bit  expV = 0, expDone = 0;
  int  expPos = 0;

  always @(posedge clk) begin
    started <= 1;
    expV = 0;
    expDone = 0;
    if (!rstN) begin
      mState = 0; mLines = 0; mCur = 0; mPix = 0; mIn = 0; expPos = 0;
    end else if (fieldStart) begin
      if (!fieldOdd) mState = 1;
      else mState = (mState == 2) ? 3 : 0;
      mLines = 0; mIn = 0;
    end else if (lineStart) begin
      if (mLines < L) begin
        mCur = mLines; mLines++; mPix = 0; mIn = 1;
      end else mIn = 0;
    end else if (pixValid && mIn) begin
      if (mState == 1) begin
        refM[mCur][mPix] = pixData;
        if (mPix == P-1 && mCur == L-1) mState = 2;
      end else if (mState == 3) begin
        int d;
        d = int'(pixData) - refM[mCur][mPix];
        if (d < 0) d = 0;
        if (mPix == 0 || d > mMaxV) begin mMaxV = d; mMaxP = mPix; end
        if (mPix == P-1) begin
          expV = 1;
          expPos = (mMaxV < int'(threshold)) ? 255 : mMaxP;
          if (mCur == L-1) begin expDone = 1; mState = 0; end
        end
      end
      mPix++;
      if (mPix == P) mIn = 0;
    end
  end

  // per-clock comparison against the model (R5, R6, values for R2 R3 R4)
  always @(negedge clk) begin
    if (started && !finished) begin
      tests++;
      if (resValid !== expV || acqDone !== expDone || (expV && resPos !== 8'(expPos))) begin
        fails++;
        $display("FAIL R5 per-clock: valid=%0d pos=%0d done=%0d expected valid=%0d pos=%0d done=%0d",
                 resValid, resPos, acqDone, expV, expPos, expDone);
      end
    end
  end

  // ---------------- result capture ----------------
  int resQ[$];
  int doneCnt = 0;
  always @(negedge clk) begin
    if (resValid) resQ.push_back(int'(resPos));
    if (acqDone) doneCnt++;
  end

  // ---------------- stimulus helpers ----------------
  function automatic int refVal(int l, int p);
    return 50 + ((l*7 + p*13) % 100);
  endfunction

  function automatic int pixVal(bit odd, int l, int p);
    int r;
    if (p >= P || l >= L) return 255;
    r = refVal(l, p);
    if (!odd) return r;
    case (l % 8)
      3: return (p == 5 || p == 9) ? r + 60 : r;
      5: return (p == 2) ? r - 40 : (p == 7) ? r + 25 : r;
      6: return (p == 11) ? r + 19 : r;
      7: return (p == 4) ? r + 20 : r;
      default: return (p == l % P) ? r + 100 : r;
    endcase
  endfunction

  // expected position at threshold 20
  function automatic int expectFor(int l);
    case (l % 8)
      3: return 5;
      5: return 7;
      6: return 255;
      7: return 4;
      default: return l % P;
    endcase
  endfunction

  task automatic send_field(bit odd, int nLines, int nPix);
    fieldStart = 1; fieldOdd = odd; pixValid = 0;
    @(negedge clk);
    fieldStart = 0;
    repeat (2) @(negedge clk);
    for (int l = 0; l < nLines; l++) begin
      lineStart = 1; pixValid = 1; pixData = 8'hFF;  // same-cycle pixel must be ignored
      @(negedge clk);
      lineStart = 0;
      for (int p = 0; p < nPix; p++) begin
        pixValid = 1; pixData = 8'(pixVal(odd, l, p));
        @(negedge clk);
        if (p % 5 == 4) begin pixValid = 0; @(negedge clk); end
      end
      pixValid = 1; pixData = 8'hFF;  // outside any line
      @(negedge clk);
      pixValid = 0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_results();
    resQ.delete();
    doneCnt = 0;
  endtask

  task automatic check_table(string tag);
    int bad = 0;
    for (int l = 0; l < L && l < resQ.size(); l++)
      if (resQ[l] != expectFor(l)) bad++;
    check(tag, bad, 0);
  endtask

  task automatic report();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10 reset resValid", int'(resValid), 0);
    check("R10 reset acqDone", int'(acqDone), 0);
    check("R10 reset resPos", int'(resPos), 0);
    rstN = 1;
    @(negedge clk);

    // odd field before any reference: nothing (R7)
    clear_results();
    send_field(1, L, P);
    check("R7 odd field without reference gives no results", resQ.size(), 0);

    // normal acquisition (R1 R2 R3 R4 R5 R6)
    clear_results();
    send_field(0, L, P);
    send_field(1, L, P);
    check("R5 result count per live field", resQ.size(), L);
    check("R6 one done pulse", doneCnt, 1);
    check("R3 tie reports earlier index (line 3)", resQ[3], 5);
    check("R2 negative difference clamped (line 5)", resQ[5], 7);
    check("R4 below threshold gives 0xFF (line 6)", resQ[6], 255);
    check("R4 equal to threshold reports position (line 7)", resQ[7], 4);
    check("R1 stored reference cancels ambient (line 9)", resQ[9], 9);
    check_table("R3 full table");

    // reference is consumed (R9)
    clear_results();
    send_field(1, L, P);
    check("R9 odd field after done gives no results", resQ.size(), 0);
    check("R9 no done without reference", doneCnt, 0);

    // truncated reference then odd field (R7)
    clear_results();
    send_field(0, 10, P);
    send_field(1, L, P);
    check("R7 partial reference then odd gives no results", resQ.size(), 0);

    // truncated even restarted by a full even (R7)
    clear_results();
    send_field(0, 40, P);
    send_field(0, L, P);
    send_field(1, L, P);
    check("R7 restart then full acquisition count", resQ.size(), L);
    check("R7 restart then done", doneCnt, 1);
    check_table("R7 restart table");

    // overlong fields: extra lines and pixels ignored (R8)
    clear_results();
    send_field(0, L + 2, P + 4);
    send_field(1, L + 2, P + 4);
    check("R8 extra lines ignored count", resQ.size(), L);
    check("R8 extra lines ignored done", doneCnt, 1);
    check_table("R8 extra pixels ignored table");

    // threshold zero: no line reports no-beam (R4)
    clear_results();
    threshold = 8'd0;
    send_field(0, L, P);
    send_field(1, L, P);
    check("R4 threshold zero, line 6 position", resQ.size() > 6 ? resQ[6] : -1, 11);
    check("R4 threshold zero, line 0 position", resQ.size() > 0 ? resQ[0] : -1, 0);

    repeat (5) @(negedge clk);
    report();
  end
endmodule